// File: doc/BRIEF.md
# Multi-voice wavetable tone synthesizer

This block produces a stream of 8-bit audio samples in which three independent tones sound at once. A prescaler divides the system clock down to a sample tick, nominally 10 kHz (one sample every 0.1 ms). On every tick, each voice reads one entry of a shared single-cycle wave table and then moves its phase forward by a programmable step. The three table values are averaged into one output word, and a one-cycle strobe marks each new sample.

A voice's pitch is set by writing its phase step through a small register-write port. In 8.8 fixed point the step is 256·f/f_sample, so a 1 kHz tone at 10 kHz uses 25.6 (0x199A) and a 500 Hz tone uses 12.8 (0x0CCD). A voice whose step is zero is silent and sits at the midpoint. A sync input restarts every voice at phase zero, so chords can be phase-aligned. The DAC, the amplifier and any note-protocol decoding live outside this block.

Top module: `tone_synth`

## Requirements
- R1: While rst_ni is low, sample_o is 128 and sample_valid_o is 0. All phases and all steps are cleared to 0.
- R2: A tick occurs on the clock edge at which the prescale count, which starts at 0 after reset and wraps after TICK_DIV-1, equals TICK_DIV-1. Ticks therefore come once every TICK_DIV clocks, and the first comes TICK_DIV edges after reset release. sample_valid_o is high for exactly the one cycle that follows each tick edge.
- R3: Each voice holds a 16-bit phase in 8.8 fixed point. On each tick edge it adds its step modulo 65536, and the index is the upper 8 bits of the phase.
- R4: Wave table entry i, for i in 0..255, has the value 128+y when i<128 and 128-y when i≥128. Here x = i mod 128 and y = floor(x·(128-x)·127/4096). So entry 0 is 128, entry 64 is 255 and entry 192 is 1.
- R5: At each tick edge, sample_o takes floor((s0+s1+s2)/3). Each s is a voice's table value at the phase that voice held before that edge's advance.
- R6: A voice whose step register holds 0 contributes 128, whatever its phase.
- R7: When wr_en_i is high, wr_data_i loads the step of the voice selected by wr_sel_i (0, 1 or 2). A wr_sel_i of 3 changes nothing. A write leaves the phase untouched. A write on a tick edge takes effect from the next tick, because that edge's advance and sample use the old step.
- R8: sync_i clears all phases to 0 at the next edge. On a tick edge, the clear takes the place of the advance, while the sample still uses the phases held before the clear.
- R9: sample_o holds its value in every cycle in which sample_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Restart all voice phases at zero |
| wr_en_i | input | 1 | Step register write strobe |
| wr_sel_i | input | 2 | Voice selected for the write |
| wr_data_i | input | 16 | Phase step in 8.8 fixed point |
| sample_o | output | 8 | Mixed output sample |
| sample_valid_o | output | 1 | One-cycle strobe for each new sample |

## Verification
Two events can land in the same cycle: a phase restart and a sample tick, and likewise a step write and a sample tick. The bench keeps its own prescale count, so it can raise sync_i, or write a step, in exactly the cycle whose edge carries a tick. The behavioural model then requires two things. The sample taken on that edge must come from the phases and steps held before the edge. The samples that follow must come from phases that restarted at zero, or that advanced by the new step only from the next tick.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int SAMPLE_W = 8;
  localparam int IDX_W    = 8;
  localparam int TBL_N    = 1 << IDX_W;
  localparam logic [SAMPLE_W-1:0] MIDPOINT = 8'd128;

  typedef logic [SAMPLE_W-1:0] sample_t;

  // parabolic approximation of one sine cycle, 1..255 around 128
  function automatic sample_t wave_value(input int i);
    int x, y;
    x = i % 128;
    y = (x * (128 - x) * 127) / 4096;
    return (i < 128) ? sample_t'(128 + y) : sample_t'(128 - y);
  endfunction
endpackage

// File: rtl/synth_tick_gen.sv
module synth_tick_gen #(
  parameter int TICK_DIV = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assert_tick_isolated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/synth_wave_rom.sv
module synth_wave_rom
  import synth_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output sample_t          data_o
);
  sample_t table_w [TBL_N];

  for (genvar g = 0; g < TBL_N; g++) begin : g_entry
    assign table_w[g] = wave_value(g);
  end

  assign data_o = table_w[idx_i];
endmodule

// File: rtl/synth_voice.sv
module synth_voice
  import synth_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               sync_i,
  input  logic [PHASE_W-1:0] step_i,
  output sample_t            sample_o
);
  logic [PHASE_W-1:0] phase_q;
  sample_t            rom_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (sync_i)  phase_q <= '0;
    else if (tick_i)  phase_q <= phase_q + step_i;
  end

  synth_wave_rom u_rom (
    .idx_i  (phase_q[PHASE_W-1 -: IDX_W]),
    .data_o (rom_data)
  );

  // zero step mutes the voice at midpoint
  assign sample_o = (step_i == '0) ? MIDPOINT : rom_data;

  assert_sync_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (phase_q == '0));
  assert_phase_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !sync_i) |=> (phase_q == PHASE_W'($past(phase_q) + $past(step_i))));
  assert_phase_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !sync_i) |=> $stable(phase_q));
endmodule

// File: rtl/synth_mixer.sv
module synth_mixer
  import synth_pkg::*;
#(
  parameter int NUM_VOICES = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              tick_i,
  input  logic [NUM_VOICES-1:0][SAMPLE_W-1:0] voice_i,
  output sample_t                           sample_o,
  output logic                              valid_o
);
  localparam int SUM_W = $clog2(NUM_VOICES * 255 + 1);

  logic [SUM_W-1:0] sum_w;
  sample_t          avg_w;

  always_comb begin
    sum_w = '0;
    for (int v = 0; v < NUM_VOICES; v++) sum_w = sum_w + SUM_W'(voice_i[v]);
  end

  assign avg_w = SAMPLE_W'(sum_w / SUM_W'(NUM_VOICES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= MIDPOINT;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= tick_i;
      if (tick_i) sample_o <= avg_w;
    end
  end

  assert_valid_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_hold_between_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o));
endmodule

// File: rtl/tone_synth.sv
module tone_synth
  import synth_pkg::*;
#(
  parameter int TICK_DIV   = 12500,
  parameter int NUM_VOICES = 3,
  parameter int PHASE_W    = 16
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              sync_i,
  input  logic                              wr_en_i,
  input  logic [$clog2(NUM_VOICES+1)-1:0]   wr_sel_i,
  input  logic [PHASE_W-1:0]                wr_data_i,
  output logic [SAMPLE_W-1:0]               sample_o,
  output logic                              sample_valid_o
);
  localparam int SEL_W = $clog2(NUM_VOICES + 1);

  logic                                tick;
  logic [PHASE_W-1:0]                  step_q [NUM_VOICES];
  logic [NUM_VOICES-1:0][SAMPLE_W-1:0] voice_smp;

  synth_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     step_q[v] <= '0;
      else if (wr_en_i && (wr_sel_i == SEL_W'(v)))     step_q[v] <= wr_data_i;
    end

    synth_voice #(.PHASE_W(PHASE_W)) u_voice (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .sync_i   (sync_i),
      .step_i   (step_q[v]),
      .sample_o (voice_smp[v])
    );

    assert_step_untouched_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && (wr_sel_i == SEL_W'(v))) |=> $stable(step_q[v]));
  end

  synth_mixer #(.NUM_VOICES(NUM_VOICES)) u_mix (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .voice_i  (voice_smp),
    .sample_o (sample_o),
    .valid_o  (sample_valid_o)
  );
endmodule

// File: tb/tb_tone_synth.sv
`timescale 1ns/1ps
module tb_tone_synth;
  localparam int DIV = 8;
  localparam int NV  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  smp;
  logic        vld;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int m_cnt;
  int m_phase [NV];
  int m_step  [NV];
  int m_out;
  bit m_vld;

  always #4 clk = ~clk;  // 125 MHz

  tone_synth #(.TICK_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .sample_o(smp), .sample_valid_o(vld)
  );

  function automatic int tbl(input int i);
    int x = i % 128;
    int y = (x * (128 - x) * 127) / 4096;
    return (i < 128) ? 128 + y : 128 - y;
  endfunction

  function automatic int voice_val(input int v);
    if (m_step[v] == 0) return 128;
    return tbl(m_phase[v] / 256);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_out = 128; m_vld = 0;
      for (int v = 0; v < NV; v++) begin m_phase[v] = 0; m_step[v] = 0; end
    end else begin
      bit t;
      int acc;
      t = (m_cnt == DIV - 1);
      m_vld = t;
      if (t) begin
        acc = 0;
        for (int v = 0; v < NV; v++) acc += voice_val(v);
        m_out = acc / 3;
      end
      for (int v = 0; v < NV; v++)
        if (sync) m_phase[v] = 0;
        else if (t) m_phase[v] = (m_phase[v] + m_step[v]) % 65536;
      if (wr_en && wr_sel < 3) m_step[wr_sel] = wr_data;
      m_cnt = t ? 0 : m_cnt + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison (R2 strobe, R5/R9 sample value)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 valid", int'(vld), int'(m_vld));
      check("R5/R9 sample", int'(smp), m_out);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic to_tick_cycle();
    while (m_cnt != DIV - 1) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    cyc(3);
    // R1 reset values
    check("R1 sample", int'(smp), 128);
    check("R1 valid", int'(vld), 0);
    rst_n = 1;

    // R2 pulse count over a window
    begin
      int n = 0;
      for (int i = 0; i < 10 * DIV; i++) begin @(negedge clk); if (vld) n++; end
      check("R2 pulses", n, 10);
    end

    // R6 all voices idle: midpoint
    check("R6 silent", int'(smp), 128);

    // R3 R4 R5: 1 kHz, 500 Hz, and a full table sweep
    wr(0, 16'h199A);
    wr(1, 16'h0CCD);
    wr(2, 16'h0100);
    cyc(260 * DIV);

    // R7 selector 3 ignored, checked through the following samples
    wr(3, 16'h4000);
    cyc(6 * DIV);

    // R7 write on a tick edge
    to_tick_cycle();
    wr(1, 16'hFFFF);
    cyc(20 * DIV);

    // R8 sync off a tick edge
    while (m_cnt != 2) @(negedge clk);
    sync = 1; @(negedge clk); sync = 0;
    cyc(5 * DIV);

    // R8 sync on a tick edge
    to_tick_cycle();
    sync = 1; @(negedge clk); sync = 0;
    cyc(12 * DIV);

    // R6 muting a voice at nonzero phase
    wr(0, 0); wr(1, 0); wr(2, 0);
    cyc(3 * DIV);
    check("R6 muted", int'(smp), 128);

    // R3 wrap with large step
    wr(0, 16'hF000);
    cyc(40 * DIV);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule